// File: doc/BRIEF.md
# Keyed Reset Line and Request Controller

This block gives software direct control over a bank of per-block reset lines and decides what happens when a hardware reset request arrives, for example a thermal alarm. Software reaches it through a small synchronous register port. Every register write carries an unlock byte in bits 31:24. The write changes the register only when that byte is the value assigned to that register. A write that carries the wrong byte, or the byte of a different register, is dropped without any effect.

Each request source has a mode bit. When the mode bit is set, the source asks for a system reset directly. When it is clear and the source's interrupt-enable bit is set, the source raises an interrupt instead. Requests are taken as levels and are assumed to be synchronous to the clock already. Both the system reset request and the interrupt follow the sources one clock later, and they stay asserted for as long as a qualifying source stays active.

Top module: `rg_top`

## Requirements
- R1: A write to address 0 (reset-line register) changes it only when wdata[31:24] is 0x88; any other value in that byte leaves the lines unchanged.
- R2: The reset-line register holds NUM_LINES (15) bits. Bit n drives rst_lines_o[n]: 1 asserts the line and 0 releases it. Write-data bits at or above NUM_LINES are discarded. After reset all lines are released. Pulsing one line takes two accepted writes, one that sets its bit and one that clears it, with the other bits written back unchanged.
- R3: A write to address 1 (request-mode register, low 24 bits stored) is accepted only when wdata[31:24] is 0x33.
- R4: A write to address 2 (request-interrupt-enable register, low 24 bits stored) is accepted only when wdata[31:24] is 0x44. A key that belongs to another register is rejected.
- R5: A read returns the stored bits of the register at addr_i in the same cycle, with bits 31:24 read as zero. Address 3 reads as zero, and writes to it have no effect.
- R6: After reset the request-mode register holds only bit 19 (debug enable) set, and dbg_en_o shows that bit. Software can clear it with an accepted write.
- R7: Request source 0 is controlled by bit 0 and source 1 by bit 18 of the mode and interrupt-enable registers. sys_rst_o is high in the cycle after a clock edge at which some req_i[k] is high and its mode bit is set, and low otherwise.
- R8: irq_o is high in the cycle after a clock edge at which some req_i[k] is high, its interrupt-enable bit is set and its mode bit is clear, and low otherwise. A set mode bit suppresses the interrupt for that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 2 | Register select (0 lines, 1 mode, 2 irq enable, 3 reserved) |
| wdata_i | input | 32 | Write data, unlock byte in bits 31:24 |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| req_i | input | 2 | Level hardware reset requests (source 0, source 1) |
| rst_lines_o | output | 15 | Per-block software reset lines, active high |
| sys_rst_o | output | 1 | System reset request |
| irq_o | output | 1 | Request interrupt |
| dbg_en_o | output | 1 | Debug enable bit of the mode register |

## Verification
The hardest case to reach is a source that is active while both its mode bit and its interrupt-enable bit are set, so that the mode bit must win. The same holds for the two sources routed to different outputs at once. Getting there requires several accepted keyed writes first. The stimulus programs the mode and enable registers through the port, then holds the request levels for several cycles and changes the routing while a request is still high. A behavioural model compares every output on every cycle, so a wrong cycle of latency or a missing hold shows up at once.

// File: rtl/rg_pkg.sv
package rg_pkg;
    localparam int REG_W   = 32;
    localparam int KEY_W   = 8;
    localparam int NUM_REQ = 2;
    localparam int DBG_POS = 19;

    localparam logic [KEY_W-1:0] KEY_LINES = 8'h88;
    localparam logic [KEY_W-1:0] KEY_MODE  = 8'h33;
    localparam logic [KEY_W-1:0] KEY_IRQEN = 8'h44;

    typedef enum logic [1:0] {
        SEL_LINES = 2'd0,
        SEL_MODE  = 2'd1,
        SEL_IRQEN = 2'd2,
        SEL_NONE  = 2'd3
    } rg_sel_e;

    typedef struct packed {
        logic sys;
        logic irq;
    } rg_out_t;

    // bit position of request source k inside the mode / enable fields
    function automatic int req_pos(input int k);
        return (k == 0) ? 0 : 18;
    endfunction
endpackage

// File: rtl/rg_keyed_reg.sv
module rg_keyed_reg #(
    parameter int               W    = 24,
    parameter logic [7:0]       KEY  = 8'h00,
    parameter logic [W-1:0]     RSTV = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_en_i,
    input  logic         hit_i,
    input  logic [7:0]   key_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (wr_en_i && hit_i && (key_i == KEY)) begin
            val_d = data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) val_q <= RSTV;
        else         val_q <= val_d;
    end

    assign q_o = val_q;
endmodule

// File: rtl/rg_req_router.sv
module rg_req_router #(
    parameter int N = 2
) (
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] mode_i,
    input  logic [N-1:0] irqen_i,
    output logic         sys_o,
    output logic         irq_o
);
    logic [N-1:0] to_sys, to_irq;

    for (genvar k = 0; k < N; k++) begin : g_src
        assign to_sys[k] = req_i[k] & mode_i[k];
        assign to_irq[k] = req_i[k] & irqen_i[k] & ~mode_i[k];
    end

    assign sys_o = |to_sys;
    assign irq_o = |to_irq;
endmodule

// File: rtl/rg_top.sv
module rg_top
    import rg_pkg::*;
#(
    parameter int NUM_LINES = 15,
    parameter int FIELD_W   = 24
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [1:0]           addr_i,
    input  logic [31:0]          wdata_i,
    output logic [31:0]          rdata_o,
    input  logic [1:0]           req_i,
    output logic [NUM_LINES-1:0] rst_lines_o,
    output logic                 sys_rst_o,
    output logic                 irq_o,
    output logic                 dbg_en_o
);
    localparam int PAD_L = REG_W - NUM_LINES;
    localparam int PAD_F = REG_W - FIELD_W;
    localparam logic [FIELD_W-1:0] MODE_RST = FIELD_W'(1) << DBG_POS;

    logic [KEY_W-1:0]     key;
    rg_sel_e              sel;
    logic [NUM_LINES-1:0] lines_q;
    logic [FIELD_W-1:0]   mode_q, irqen_q;
    logic [NUM_REQ-1:0]   mode_src, irqen_src;
    logic                 sys_hit, irq_hit;
    rg_out_t              out_d, out_q;

    assign key = wdata_i[REG_W-1 -: KEY_W];
    assign sel = rg_sel_e'(addr_i);

    rg_keyed_reg #(.W(NUM_LINES), .KEY(KEY_LINES), .RSTV('0)) u_lines (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_en_i(wr_en_i),
        .hit_i  (sel == SEL_LINES),
        .key_i  (key),
        .data_i (wdata_i[NUM_LINES-1:0]),
        .q_o    (lines_q)
    );

    rg_keyed_reg #(.W(FIELD_W), .KEY(KEY_MODE), .RSTV(MODE_RST)) u_mode (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_en_i(wr_en_i),
        .hit_i  (sel == SEL_MODE),
        .key_i  (key),
        .data_i (wdata_i[FIELD_W-1:0]),
        .q_o    (mode_q)
    );

    rg_keyed_reg #(.W(FIELD_W), .KEY(KEY_IRQEN), .RSTV('0)) u_irqen (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_en_i(wr_en_i),
        .hit_i  (sel == SEL_IRQEN),
        .key_i  (key),
        .data_i (wdata_i[FIELD_W-1:0]),
        .q_o    (irqen_q)
    );

    for (genvar k = 0; k < NUM_REQ; k++) begin : g_pick
        assign mode_src[k]  = mode_q[req_pos(k)];
        assign irqen_src[k] = irqen_q[req_pos(k)];
    end

    rg_req_router #(.N(NUM_REQ)) u_router (
        .req_i  (req_i),
        .mode_i (mode_src),
        .irqen_i(irqen_src),
        .sys_o  (sys_hit),
        .irq_o  (irq_hit)
    );

    always_comb begin
        out_d     = out_q;
        out_d.sys = sys_hit;
        out_d.irq = irq_hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    always_comb begin
        unique case (sel)
            SEL_LINES: rdata_o = {{PAD_L{1'b0}}, lines_q};
            SEL_MODE:  rdata_o = {{PAD_F{1'b0}}, mode_q};
            SEL_IRQEN: rdata_o = {{PAD_F{1'b0}}, irqen_q};
            default:   rdata_o = '0;
        endcase
    end

    assign rst_lines_o = lines_q;
    assign sys_rst_o   = out_q.sys;
    assign irq_o       = out_q.irq;
    assign dbg_en_o    = mode_q[DBG_POS];
endmodule

// File: rtl/rg_chk.sv
module rg_chk #(
    parameter int NUM_LINES = 15,
    parameter int FIELD_W   = 24
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 wr_en_i,
    input logic [1:0]           addr_i,
    input logic [31:0]          wdata_i,
    input logic [1:0]           req_i,
    input logic [NUM_LINES-1:0] rst_lines_o,
    input logic                 sys_rst_o,
    input logic                 irq_o,
    input logic [FIELD_W-1:0]   mode_q,
    input logic [FIELD_W-1:0]   irqen_q
);
    logic want_sys, want_irq;
    assign want_sys = (req_i[0] & mode_q[0]) | (req_i[1] & mode_q[18]);
    assign want_irq = (req_i[0] & irqen_q[0] & ~mode_q[0]) |
                      (req_i[1] & irqen_q[18] & ~mode_q[18]);

    a_r1_lines_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 2'd0 && wdata_i[31:24] != 8'h88) |=> $stable(rst_lines_o));

    a_r2_lines_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 2'd0 && wdata_i[31:24] == 8'h88)
        |=> rst_lines_o == $past(wdata_i[NUM_LINES-1:0]));

    a_r3_mode_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 2'd1 && wdata_i[31:24] != 8'h33) |=> $stable(mode_q));

    a_r4_irqen_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 2'd2 && wdata_i[31:24] != 8'h44) |=> $stable(irqen_q));

    a_r5_reserved_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 2'd3)
        |=> ($stable(rst_lines_o) && $stable(mode_q) && $stable(irqen_q)));

    a_r7_sys_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        want_sys |=> sys_rst_o);

    a_r7_sys_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !want_sys |=> !sys_rst_o);

    a_r8_irq_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        want_irq |=> irq_o);

    a_r8_irq_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !want_irq |=> !irq_o);
endmodule

bind rg_top rg_chk #(.NUM_LINES(NUM_LINES), .FIELD_W(FIELD_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .req_i      (req_i),
    .rst_lines_o(rst_lines_o),
    .sys_rst_o  (sys_rst_o),
    .irq_o      (irq_o),
    .mode_q     (mode_q),
    .irqen_q    (irqen_q)
);

// File: tb/test_rg_top.sv
module test_rg_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  addr_i = 2'd0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [1:0]  req_i = 2'b00;
    logic [14:0] rst_lines_o;
    logic        sys_rst_o, irq_o, dbg_en_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk_i = ~clk_i;   // 50 MHz

    rg_top i_rg_top (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .req_i(req_i),
        .rst_lines_o(rst_lines_o), .sys_rst_o(sys_rst_o), .irq_o(irq_o),
        .dbg_en_o(dbg_en_o)
    );

    // behavioural reference model
    int unsigned m_lines, m_mode, m_irqen;
    bit m_sys, m_irq;

    always @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            m_lines <= 0; m_mode <= 32'h0008_0000; m_irqen <= 0;
            m_sys <= 0; m_irq <= 0;
        end else begin
            if (wr_en_i) begin
                if (addr_i == 2'd0 && wdata_i[31:24] == 8'h88) m_lines <= wdata_i & 32'h7FFF;
                if (addr_i == 2'd1 && wdata_i[31:24] == 8'h33) m_mode  <= wdata_i & 32'hFF_FFFF;
                if (addr_i == 2'd2 && wdata_i[31:24] == 8'h44) m_irqen <= wdata_i & 32'hFF_FFFF;
            end
            m_sys <= (req_i[0] && m_mode[0]) || (req_i[1] && m_mode[18]);
            m_irq <= (req_i[0] && m_irqen[0] && !m_mode[0]) ||
                     (req_i[1] && m_irqen[18] && !m_mode[18]);
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison
    always @(negedge clk_i) begin
        if (rst_ni && !done) begin
            int unsigned exp_rd;
            case (addr_i)
                2'd0: exp_rd = m_lines;
                2'd1: exp_rd = m_mode;
                2'd2: exp_rd = m_irqen;
                default: exp_rd = 0;
            endcase
            chk("R2 lines", rst_lines_o, m_lines);
            chk("R7 sys_rst", sys_rst_o, m_sys);
            chk("R8 irq", irq_o, m_irq);
            chk("R6 dbg_en", dbg_en_o, m_mode[19]);
            chk("R5 rdata", rdata_o, exp_rd);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk_i); #1;
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk_i); #1;
        wr_en_i = 1'b0; wdata_i = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk_i); #1;
        addr_i = a;
        #2;
        chk(tag, rdata_o, exp);
    endtask

    task automatic set_req(input logic [1:0] r, input int hold);
        @(negedge clk_i); #1;
        req_i = r;
        for (int i = 0; i < hold; i++) @(negedge clk_i);
    endtask

    initial begin
        #(200000 * 20);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        #1 rst_ni = 1'b1;
        // reset state
        @(negedge clk_i); #2;
        chk("R2 reset lines", rst_lines_o, 0);
        chk("R6 reset dbg", dbg_en_o, 1);
        rd(2'd1, 32'h0008_0000, "R6 reset mode");
        rd(2'd2, 32'h0, "R4 reset irqen");
        // R1 keyed line writes
        wr(2'd0, 32'h8800_0005);
        rd(2'd0, 32'h5, "R1 accepted");
        wr(2'd0, 32'h8700_7FFF);
        rd(2'd0, 32'h5, "R1 wrong key");
        wr(2'd0, 32'h3300_7FFF);
        rd(2'd0, 32'h5, "R1 foreign key");
        // R2 single-line pulse on line 3, masking above bit 14
        wr(2'd0, 32'h8800_000D);
        chk("R2 line3 set", rst_lines_o, 15'h000D);
        wr(2'd0, 32'h8800_0005);
        chk("R2 line3 clr", rst_lines_o, 15'h0005);
        wr(2'd0, 32'h88FF_FFFF);
        rd(2'd0, 32'h7FFF, "R2 high bits dropped");
        // R5 reserved address
        wr(2'd3, 32'h88FF_FFFF);
        rd(2'd3, 32'h0, "R5 reserved reads zero");
        rd(2'd0, 32'h7FFF, "R5 reserved write ignored");
        // R3 mode key
        wr(2'd1, 32'h4400_0001);
        rd(2'd1, 32'h0008_0000, "R3 wrong key");
        wr(2'd1, 32'h3300_0000);
        rd(2'd1, 32'h0, "R3 accepted, R6 debug cleared");
        chk("R6 dbg low", dbg_en_o, 0);
        // R4 irq enable key
        wr(2'd2, 32'h3304_0001);
        rd(2'd2, 32'h0, "R4 foreign key");
        wr(2'd2, 32'h4404_0001);
        rd(2'd2, 32'h0004_0001, "R4 accepted");
        // R8: both sources to interrupt
        set_req(2'b01, 4);
        chk("R8 irq src0", irq_o, 1);
        chk("R7 no sys src0", sys_rst_o, 0);
        set_req(2'b10, 4);
        chk("R8 irq src1", irq_o, 1);
        set_req(2'b00, 3);
        chk("R8 irq released", irq_o, 0);
        // R7: source 0 to reset, source 1 still to interrupt
        wr(2'd1, 32'h3300_0001);
        set_req(2'b01, 5);
        chk("R7 sys held", sys_rst_o, 1);
        chk("R8 mode suppresses irq", irq_o, 0);
        set_req(2'b11, 3);
        chk("R7 sys both", sys_rst_o, 1);
        chk("R8 irq src1 alongside", irq_o, 1);
        // reroute while request is held
        wr(2'd1, 32'h3304_0000);
        set_req(2'b11, 3);
        chk("R7 src1 to reset", sys_rst_o, 1);
        chk("R8 src0 to irq", irq_o, 1);
        set_req(2'b00, 3);
        chk("R7 released", sys_rst_o, 0);
        // disabled source ignored
        wr(2'd2, 32'h4400_0000);
        wr(2'd1, 32'h3300_0000);
        set_req(2'b11, 3);
        chk("R8 disabled no irq", irq_o, 0);
        chk("R7 disabled no sys", sys_rst_o, 0);
        set_req(2'b00, 2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule